// File: doc/BRIEF.md
# Page Migration Sequencer

This block coordinates the move of a single page from the device that currently holds it to a device that took a translation fault on it. A fault arrives as a valid/ready request with the virtual page number, the faulting device, the holding device, the page's present physical page number and a page-size code. The sequencer then runs a fixed chain of request/acknowledge exchanges with its neighbours. It flushes the holding device, starts the page copy, and rewrites the page table entry. It then lets the holder replay its flushed accesses and pushes the fresh translation into the faulting device's second-level and then first-level TLB.

Translation coherence depends on this order. No copy starts until all three flush parts on the holder have acknowledged. The holder's pipeline flush, its in-flight cache and TLB transactions, and its stored cache and TLB contents each count as one part. Only one migration is in flight at a time. The flush wait and the copy wait are each bounded by a programmable cycle limit, and overrunning either one parks the block in an error state until software clears it. A fault where the faulting and holding devices are the same needs no data movement, so the sequencer goes straight to the TLB refill and flags it as spurious.

Top module: `pgmig_seq`

## Requirements
- R1: After reset, fault_ready is 1 and err, done and every request output are 0.
- R2: A fault is taken when fault_valid and fault_ready are both 1. For a non-spurious fault, flush_req[0] (pipeline), flush_req[1] (in-flight cache/TLB transactions) and flush_req[2] (cache/TLB contents) then all rise, with op_src_dev naming the holding device. Each bit stays high until its own acknowledge is sampled.
- R3: copy_req rises only after all three flush acknowledges have been seen. While it is high, op_src_dev is the holder and op_dst_dev is the faulting device.
- R4: op_pages gives the page length in 4 KB units. Size code 0 gives 1 (4 KB), code 1 gives 16 (64 KB), and codes 2 and 3 give 512 (2 MB).
- R5: The copy_ppn value sampled with copy_ack becomes op_ppn. pte_req then rises with op_vpn and op_ppn set. After pte_ack, replay_req rises towards the holder (op_src_dev).
- R6: After replay_ack, tlb2_req rises, and only after tlb2_ack does tlb1_req rise. Both carry op_vpn and op_ppn. At most one step request is ever active at a time.
- R7: The cycle after the tlb1 handshake, done is high for exactly one cycle. At that point done_ppn is the new physical page, done_dev is the faulting device and done_spurious is 0.
- R8: When the faulting and holding device IDs are equal, no flush, copy, table-update or replay request is made. The sequence begins at tlb2_req with op_ppn equal to fault_ppn, and done_spurious is 1 with the done pulse.
- R9: fault_ready is 0 from the cycle after a fault is taken until the sequence returns to idle. A waiting fault is taken only after that.
- R10: In the flush wait and in the copy wait, an acknowledge is accepted if it is sampled no later than tmo_cycles cycles after the first cycle of that wait. Otherwise err rises one cycle after the limit.
- R11: While err is 1, every request output and fault_ready are 0. err stays 1 until a cycle with err_clr high, after which the block is idle with fault_ready 1.
- R12: An acknowledge that arrives while its request is low has no effect: the state, fault_ready and done are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | Fault request valid |
| fault_ready | output | 1 | Sequencer idle and able to take a fault |
| fault_vpn | input | VPN_W | Faulting virtual page number |
| fault_req_dev | input | DEV_W | Device that took the fault |
| fault_own_dev | input | DEV_W | Device currently holding the page |
| fault_ppn | input | PPN_W | Present physical page number |
| fault_psize | input | 2 | Page-size code |
| tmo_cycles | input | TMO_W | Wait limit for flush and copy acknowledges |
| err_clr | input | 1 | Clears the error state |
| err | output | 1 | Timeout error state |
| flush_req | output | 3 | Flush requests: pipeline, in-flight, contents |
| flush_ack | input | 3 | Flush acknowledges, same bit order |
| copy_req | output | 1 | Page copy request |
| copy_ack | input | 1 | Page copy complete |
| copy_ppn | input | PPN_W | Destination physical page, valid with copy_ack |
| pte_req | output | 1 | Page table entry update request |
| pte_ack | input | 1 | Page table entry update done |
| replay_req | output | 1 | Holder may replay flushed accesses |
| replay_ack | input | 1 | Replay done |
| tlb2_req | output | 1 | Second-level TLB refill request |
| tlb2_ack | input | 1 | Second-level TLB refill done |
| tlb1_req | output | 1 | First-level TLB refill request |
| tlb1_ack | input | 1 | First-level TLB refill done |
| op_vpn | output | VPN_W | Virtual page of the migration in progress |
| op_src_dev | output | DEV_W | Holding device |
| op_dst_dev | output | DEV_W | Faulting device |
| op_pages | output | 10 | Page length in 4 KB units |
| op_ppn | output | PPN_W | Physical page for table update and refill |
| done | output | 1 | One-cycle completion pulse |
| done_ppn | output | PPN_W | New physical page, valid with done |
| done_dev | output | DEV_W | Faulting device, valid with done |
| done_spurious | output | 1 | Fault needed no migration |

## Verification
The bench uses VPN_W=20, PPN_W=16, DEV_W=2 and TMO_W=4. The narrow limit field keeps each wait window a few cycles long, so a test can place an acknowledge exactly on the last accepted cycle and one cycle past it. The short device field makes it cheap to pick equal and unequal device pairs for the spurious bypass. Per-channel acknowledge latencies are set per test, including equal flush latencies and a stalled channel, so that flush completion in different orders, a migration waiting behind a busy sequencer, and recovery from both kinds of timeout all appear in one run.

// File: rtl/pgmig_pkg.sv
package pgmig_pkg;

  localparam int unsigned FL_PARTS = 3;
  localparam int unsigned PG_W     = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_COPY,
    ST_PTE,
    ST_REPLAY,
    ST_TLB2,
    ST_TLB1,
    ST_ERR
  } mig_st_e;

  // page length in 4 KB units for a size code
  function automatic logic [PG_W-1:0] pages_of(input logic [1:0] sz);
    logic [PG_W-1:0] one;
    one = {{(PG_W-1){1'b0}}, 1'b1};
    case (sz)
      2'd0:    pages_of = one;
      2'd1:    pages_of = one << 4;
      default: pages_of = one << 9;
    endcase
  endfunction

endpackage

// File: rtl/pgmig_rst_sync.sv
module pgmig_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pgmig_flush_track.sv
module pgmig_flush_track #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [N-1:0] ack,
  output logic [N-1:0] req,
  output logic         all_done
);

  logic [N-1:0] got_q, got_d;

  always_comb begin
    got_d = '0;
    if (active) got_d = got_q | (ack & req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) got_q <= '0;
    else        got_q <= got_d;
  end

  assign req      = active ? ~got_q : '0;
  assign all_done = active && (&(got_q | ack));

  // each flush part stays requested until its own acknowledge (R2)
  for (genvar i = 0; i < N; i++) begin : g_chk
    p_flush_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req[i] && !ack[i] && active |=> req[i] || !active);
  end

endmodule

// File: rtl/pgmig_wait_timer.sv
module pgmig_wait_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expired
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run)       cnt_d = '0;
    else if (cnt_q != '1)  cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == limit);

  // a running wait never counts past its limit (R10)
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= limit);

endmodule

// File: rtl/pgmig_seq.sv
module pgmig_seq
  import pgmig_pkg::*;
#(
  parameter int unsigned VPN_W = 36,
  parameter int unsigned PPN_W = 28,
  parameter int unsigned DEV_W = 2,
  parameter int unsigned TMO_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fault_valid,
  output logic                fault_ready,
  input  logic [VPN_W-1:0]    fault_vpn,
  input  logic [DEV_W-1:0]    fault_req_dev,
  input  logic [DEV_W-1:0]    fault_own_dev,
  input  logic [PPN_W-1:0]    fault_ppn,
  input  logic [1:0]          fault_psize,
  input  logic [TMO_W-1:0]    tmo_cycles,
  input  logic                err_clr,
  output logic                err,
  output logic [FL_PARTS-1:0] flush_req,
  input  logic [FL_PARTS-1:0] flush_ack,
  output logic                copy_req,
  input  logic                copy_ack,
  input  logic [PPN_W-1:0]    copy_ppn,
  output logic                pte_req,
  input  logic                pte_ack,
  output logic                replay_req,
  input  logic                replay_ack,
  output logic                tlb2_req,
  input  logic                tlb2_ack,
  output logic                tlb1_req,
  input  logic                tlb1_ack,
  output logic [VPN_W-1:0]    op_vpn,
  output logic [DEV_W-1:0]    op_src_dev,
  output logic [DEV_W-1:0]    op_dst_dev,
  output logic [PG_W-1:0]     op_pages,
  output logic [PPN_W-1:0]    op_ppn,
  output logic                done,
  output logic [PPN_W-1:0]    done_ppn,
  output logic [DEV_W-1:0]    done_dev,
  output logic                done_spurious
);

  logic rst_ni;
  mig_st_e st_q, st_d;

  logic [VPN_W-1:0] vpn_q;
  logic [DEV_W-1:0] rdev_q, odev_q;
  logic [PPN_W-1:0] ppn_q, ppn_d;
  logic [1:0]       psz_q;
  logic             spur_q;
  logic             ctx_en, ppn_en;
  logic             done_q, done_d;

  logic accept, fl_active, fl_all, tmr_run, tmr_clr, tmr_exp;

  pgmig_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ni)
  );

  assign fault_ready = (st_q == ST_IDLE);
  assign accept      = fault_valid && fault_ready;
  assign fl_active   = (st_q == ST_FLUSH);

  pgmig_flush_track #(.N(FL_PARTS)) u_flush (
    .clk      (clk),
    .rst_n    (rst_ni),
    .active   (fl_active),
    .ack      (flush_ack),
    .req      (flush_req),
    .all_done (fl_all)
  );

  assign tmr_run = (st_q == ST_FLUSH) || (st_q == ST_COPY);
  assign tmr_clr = (st_d != st_q);

  pgmig_wait_timer #(.W(TMO_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (tmr_run),
    .clr     (tmr_clr),
    .limit   (tmo_cycles),
    .expired (tmr_exp)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = (fault_req_dev == fault_own_dev) ? ST_TLB2 : ST_FLUSH;
      ST_FLUSH:  if (fl_all) st_d = ST_COPY; else if (tmr_exp) st_d = ST_ERR;
      ST_COPY:   if (copy_ack) st_d = ST_PTE; else if (tmr_exp) st_d = ST_ERR;
      ST_PTE:    if (pte_ack) st_d = ST_REPLAY;
      ST_REPLAY: if (replay_ack) st_d = ST_TLB2;
      ST_TLB2:   if (tlb2_ack) st_d = ST_TLB1;
      ST_TLB1:   if (tlb1_ack) st_d = ST_IDLE;
      ST_ERR:    if (err_clr) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // migration context, loaded on accept; page number replaced on copy completion
  assign ctx_en = accept;
  assign ppn_en = accept || (copy_req && copy_ack);
  assign ppn_d  = accept ? fault_ppn : copy_ppn;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q  <= '0;
      rdev_q <= '0;
      odev_q <= '0;
      psz_q  <= '0;
      spur_q <= 1'b0;
    end else if (ctx_en) begin
      vpn_q  <= fault_vpn;
      rdev_q <= fault_req_dev;
      odev_q <= fault_own_dev;
      psz_q  <= fault_psize;
      spur_q <= (fault_req_dev == fault_own_dev);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ppn_q <= '0;
    else if (ppn_en) ppn_q <= ppn_d;
  end

  assign done_d = (st_q == ST_TLB1) && tlb1_ack;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign copy_req   = (st_q == ST_COPY);
  assign pte_req    = (st_q == ST_PTE);
  assign replay_req = (st_q == ST_REPLAY);
  assign tlb2_req   = (st_q == ST_TLB2);
  assign tlb1_req   = (st_q == ST_TLB1);
  assign err        = (st_q == ST_ERR);

  assign op_vpn        = vpn_q;
  assign op_src_dev    = odev_q;
  assign op_dst_dev    = rdev_q;
  assign op_pages      = pages_of(psz_q);
  assign op_ppn        = ppn_q;
  assign done          = done_q;
  assign done_ppn      = ppn_q;
  assign done_dev      = rdev_q;
  assign done_spurious = spur_q;

  // copy only starts once the tracker has seen every flush part (R3)
  p_copy_after_flush_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(copy_req) |-> $past(fl_all));

  // first-level refill follows a completed second-level refill (R6)
  p_tlb_order_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(tlb1_req) |-> $past(tlb2_req && tlb2_ack));

  // steps never overlap (R6)
  p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({|flush_req, copy_req, pte_req, replay_req, tlb2_req, tlb1_req}));

  // done lasts one cycle (R7)
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // a taken fault makes the sequencer busy (R9)
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    fault_valid && fault_ready |=> !fault_ready);

  // error is sticky until cleared (R11)
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    err && !err_clr |=> err);

  // no request leaves the block in error (R11)
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    err |-> !(|flush_req || copy_req || pte_req || replay_req || tlb2_req || tlb1_req));

endmodule

// File: tb/pgmig_seq_tb.sv
module pgmig_seq_tb;
  import pgmig_pkg::*;

  localparam int VPN_W = 20;
  localparam int PPN_W = 16;
  localparam int DEV_W = 2;
  localparam int TMO_W = 4;

  logic clk, rst_n;
  logic fault_valid, fault_ready;
  logic [VPN_W-1:0] fault_vpn;
  logic [DEV_W-1:0] fault_req_dev, fault_own_dev;
  logic [PPN_W-1:0] fault_ppn, copy_ppn;
  logic [1:0] fault_psize;
  logic [TMO_W-1:0] tmo_cycles;
  logic err_clr, err;
  logic [2:0] flush_req;
  logic copy_req, pte_req, replay_req, tlb2_req, tlb1_req;
  logic [VPN_W-1:0] op_vpn;
  logic [DEV_W-1:0] op_src_dev, op_dst_dev, done_dev;
  logic [PG_W-1:0] op_pages;
  logic [PPN_W-1:0] op_ppn, done_ppn;
  logic done, done_spurious;

  logic [7:0] req_v;
  logic [7:0] ack_v;
  int lat [8];
  bit stall [8];
  int cnt [8];

  assign req_v = {tlb1_req, tlb2_req, replay_req, pte_req, copy_req, flush_req};

  pgmig_seq #(.VPN_W(VPN_W), .PPN_W(PPN_W), .DEV_W(DEV_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fault_valid(fault_valid), .fault_ready(fault_ready),
    .fault_vpn(fault_vpn), .fault_req_dev(fault_req_dev), .fault_own_dev(fault_own_dev),
    .fault_ppn(fault_ppn), .fault_psize(fault_psize),
    .tmo_cycles(tmo_cycles), .err_clr(err_clr), .err(err),
    .flush_req(flush_req), .flush_ack(ack_v[2:0]),
    .copy_req(copy_req), .copy_ack(ack_v[3]), .copy_ppn(copy_ppn),
    .pte_req(pte_req), .pte_ack(ack_v[4]),
    .replay_req(replay_req), .replay_ack(ack_v[5]),
    .tlb2_req(tlb2_req), .tlb2_ack(ack_v[6]),
    .tlb1_req(tlb1_req), .tlb1_ack(ack_v[7]),
    .op_vpn(op_vpn), .op_src_dev(op_src_dev), .op_dst_dev(op_dst_dev),
    .op_pages(op_pages), .op_ppn(op_ppn),
    .done(done), .done_ppn(done_ppn), .done_dev(done_dev), .done_spurious(done_spurious)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_done = 0;
  bit finished = 0;

  typedef struct { int code; logic [63:0] pl; } ev_t;
  typedef struct { logic [PPN_W-1:0] ppn; logic [DEV_W-1:0] dev; logic sp; } dn_t;
  ev_t exp_q[$];
  dn_t dn_q[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  function automatic string tag_of(input int code);
    if (code < 3) return "R2";
    if (code == 3) return "R3";
    if (code < 6) return "R5";
    return "R6";
  endfunction

  function automatic logic [63:0] pay(input int code);
    case (code)
      0, 1, 2, 5: pay = 64'(op_src_dev);
      3:          pay = 64'({op_src_dev, op_dst_dev, op_pages});
      default:    pay = 64'({op_vpn, op_ppn});
    endcase
  endfunction

  // acknowledge responders
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < 8; i++) begin
      if (ack_v[i]) begin
        ack_v[i] = 1'b0;
        cnt[i] = 0;
      end else if (req_v[i] && !stall[i]) begin
        if (cnt[i] >= lat[i]) ack_v[i] = 1'b1;
        else cnt[i]++;
      end else if (!req_v[i]) begin
        cnt[i] = 0;
      end
    end
  end

  // monitor: handshakes and completions against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 8; i++) begin
        if (req_v[i] && ack_v[i]) begin
          if (exp_q.size() == 0) begin
            chk(0, tag_of(i), "unexpected handshake", 64'(i), 64'hFF);
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            chk(e.code == i, tag_of(e.code), "step order", 64'(i), 64'(e.code));
            chk(e.pl == pay(i), tag_of(i), "step payload", pay(i), e.pl);
          end
        end
      end
      if (done) begin
        n_done++;
        if (dn_q.size() == 0) begin
          chk(0, "R7", "unexpected done", 64'(done_ppn), 64'h0);
        end else begin
          dn_t d;
          d = dn_q.pop_front();
          chk(done_ppn == d.ppn, d.sp ? "R8" : "R7", "done_ppn", 64'(done_ppn), 64'(d.ppn));
          chk(done_dev == d.dev, "R7", "done_dev", 64'(done_dev), 64'(d.dev));
          chk(done_spurious == d.sp, "R8", "done_spurious", 64'(done_spurious), 64'(d.sp));
        end
      end
    end
  end

  function automatic logic [PG_W-1:0] exp_pages(input logic [1:0] sz);
    if (sz == 2'd0) return 10'd1;
    if (sz == 2'd1) return 10'd16;
    return 10'd512;
  endfunction

  // driver side: expected steps of one migration; nsteps limits how far it gets
  task automatic push_exp(input logic [VPN_W-1:0] vpn, input logic [DEV_W-1:0] rdev,
                          input logic [DEV_W-1:0] odev, input logic [PPN_W-1:0] fppn,
                          input logic [1:0] psz, input logic [PPN_W-1:0] nppn,
                          input int upto);
    ev_t e;
    if (rdev == odev) begin
      e.code = 6; e.pl = 64'({vpn, fppn}); exp_q.push_back(e);
      e.code = 7; exp_q.push_back(e);
      dn_q.push_back('{fppn, rdev, 1'b1});
      return;
    end
    for (int l = 0; l < 16; l++)
      for (int i = 0; i < 3; i++)
        if (lat[i] == l && !stall[i]) begin
          e.code = i; e.pl = 64'(odev); exp_q.push_back(e);
        end
    if (upto < 3) return;
    e.code = 3; e.pl = 64'({odev, rdev, exp_pages(psz)}); exp_q.push_back(e);
    e.code = 4; e.pl = 64'({vpn, nppn}); exp_q.push_back(e);
    e.code = 5; e.pl = 64'(odev); exp_q.push_back(e);
    e.code = 6; e.pl = 64'({vpn, nppn}); exp_q.push_back(e);
    e.code = 7; exp_q.push_back(e);
    dn_q.push_back('{nppn, rdev, 1'b0});
  endtask

  task automatic issue(input logic [VPN_W-1:0] vpn, input logic [DEV_W-1:0] rdev,
                       input logic [DEV_W-1:0] odev, input logic [PPN_W-1:0] fppn,
                       input logic [1:0] psz, input logic [PPN_W-1:0] nppn);
    @(negedge clk);
    fault_valid = 1'b1; fault_vpn = vpn; fault_req_dev = rdev;
    fault_own_dev = odev; fault_ppn = fppn; fault_psize = psz;
    forever begin
      if (fault_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    fault_valid = 1'b0;
    copy_ppn = nppn;
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) @(negedge clk);
  endtask

  task automatic set_lat(input int f0, input int f1, input int f2, input int rest);
    lat[0] = f0; lat[1] = f1; lat[2] = f2;
    for (int i = 3; i < 8; i++) lat[i] = rest;
    for (int i = 0; i < 8; i++) stall[i] = 0;
  endtask

  task automatic mig(input logic [VPN_W-1:0] vpn, input logic [DEV_W-1:0] rdev,
                     input logic [DEV_W-1:0] odev, input logic [PPN_W-1:0] fppn,
                     input logic [1:0] psz, input logic [PPN_W-1:0] nppn);
    int target;
    target = n_done + 1;
    push_exp(vpn, rdev, odev, fppn, psz, nppn, 9);
    issue(vpn, rdev, odev, fppn, psz, nppn);
    wait_done(target);
    chk(exp_q.size() == 0, "R6", "steps left after done", 64'(exp_q.size()), 64'h0);
  endtask

  task automatic expect_error(input string rq);
    int guard;
    guard = 0;
    while (!err && guard < 60) begin @(negedge clk); guard++; end
    chk(err == 1'b1, rq, "err after timeout", 64'(err), 64'h1);
    chk(exp_q.size() == 0, rq, "steps before timeout", 64'(exp_q.size()), 64'h0);
    chk(req_v == 8'h0, "R11", "requests in error", 64'(req_v), 64'h0);
    chk(fault_ready == 1'b0, "R11", "ready in error", 64'(fault_ready), 64'h0);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R11", "err held", 64'(err), 64'h1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err == 1'b0, "R11", "err after clear", 64'(err), 64'h0);
    chk(fault_ready == 1'b1, "R11", "ready after clear", 64'(fault_ready), 64'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fault_valid = 1'b0; fault_vpn = '0; fault_req_dev = '0;
    fault_own_dev = '0; fault_ppn = '0; fault_psize = '0; copy_ppn = '0;
    tmo_cycles = 4'd15; err_clr = 1'b0; ack_v = '0;
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    set_lat(1, 3, 2, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(fault_ready == 1'b1, "R1", "fault_ready", 64'(fault_ready), 64'h1);
    chk(req_v == 8'h0, "R1", "requests", 64'(req_v), 64'h0);
    chk(err == 1'b0 && done == 1'b0, "R1", "err/done", 64'({err, done}), 64'h0);

    // R2 R3 R5 R6 R7: plain migration, flush parts finishing out of order, 4 KB
    mig(20'h12345, 2'd2, 2'd1, 16'h00AA, 2'd0, 16'h01B2);
    // R4: 64 KB with zero-latency neighbours
    set_lat(0, 0, 0, 0);
    mig(20'h0BEEF, 2'd0, 2'd3, 16'h1111, 2'd1, 16'h2222);
    // R4: 2 MB, tied flush latencies
    set_lat(2, 2, 0, 2);
    mig(20'h7F000, 2'd1, 2'd2, 16'h3333, 2'd2, 16'h4444);
    set_lat(1, 0, 2, 0);
    mig(20'h00042, 2'd3, 2'd0, 16'h5555, 2'd3, 16'h6666);

    // R8 spurious fault
    set_lat(1, 1, 1, 1);
    mig(20'h55555, 2'd3, 2'd3, 16'h0077, 2'd2, 16'h9999);

    // R9 second fault waits while busy
    set_lat(3, 2, 1, 3);
    begin
      int target;
      target = n_done + 2;
      push_exp(20'h00111, 2'd0, 2'd1, 16'h0101, 2'd0, 16'h0A0A, 9);
      issue(20'h00111, 2'd0, 2'd1, 16'h0101, 2'd0, 16'h0A0A);
      push_exp(20'h00222, 2'd1, 2'd0, 16'h0202, 2'd1, 16'h0A0A, 9);
      fork
        issue(20'h00222, 2'd1, 2'd0, 16'h0202, 2'd1, 16'h0A0A);
      join_none
      repeat (3) begin
        @(negedge clk);
        chk(fault_ready == 1'b0, "R9", "ready while busy", 64'(fault_ready), 64'h0);
      end
      wait_done(target);
      chk(exp_q.size() == 0, "R9", "queued fault completed", 64'(exp_q.size()), 64'h0);
    end

    // R10 acknowledges landing on the last accepted cycle
    tmo_cycles = 4'd4;
    set_lat(4, 4, 4, 4);
    mig(20'h0ABCD, 2'd2, 2'd0, 16'h0C0C, 2'd0, 16'h0D0D);

    // R10 R11 flush part never acknowledged
    set_lat(0, 0, 0, 1);
    stall[1] = 1;
    push_exp(20'h0F0F0, 2'd1, 2'd2, 16'h0E0E, 2'd0, 16'h0F0F, 0);
    issue(20'h0F0F0, 2'd1, 2'd2, 16'h0E0E, 2'd0, 16'h0F0F);
    expect_error("R10");
    stall[1] = 0;

    // R10 R11 copy one cycle too late
    set_lat(0, 1, 2, 1);
    lat[3] = 5;
    push_exp(20'h0AAAA, 2'd0, 2'd3, 16'h1234, 2'd1, 16'h4321, 0);
    issue(20'h0AAAA, 2'd0, 2'd3, 16'h1234, 2'd1, 16'h4321);
    expect_error("R10");

    // R12 stray acknowledges while idle
    set_lat(0, 0, 0, 0);
    tmo_cycles = 4'd15;
    @(negedge clk);
    ack_v = 8'hFF;
    @(negedge clk);
    chk(fault_ready == 1'b1, "R12", "ready after stray ack", 64'(fault_ready), 64'h1);
    chk(req_v == 8'h0 && done == 1'b0 && err == 1'b0, "R12", "state after stray ack",
        64'({req_v, done, err}), 64'h0);
    repeat (2) @(negedge clk);
    mig(20'h13579, 2'd1, 2'd3, 16'h2468, 2'd2, 16'h8642);

    chk(dn_q.size() == 0, "R7", "done items left", 64'(dn_q.size()), 64'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule